// File: doc/BRIEF.md
# High-Speed Capability Negotiator (Device Side)

This block runs on the device end of a serial bus link while the bus is held in reset. When a reset is reported to it, the block connects the full-speed pull-up on the positive data line and removes the high-speed termination. It waits for the line to show SE0 and then drives a chirp K for a bounded number of ticks. After that it listens for the hub's reply, which is a train of alternating chirp K and chirp J levels. Each level counts only after it has held steady through a glitch filter. When enough filtered K-then-J pairs arrive, the block switches to high-speed. It enables the termination, drops the pull-up and raises a high-speed flag. If the listening window closes first, it stays at full-speed.

All durations are parameters counted in ticks of a slow clock, so the block can run at a parallel-interface rate or slower. It takes a pre-decoded line state from the receiver and a one-cycle reset strobe. Its outputs are the enables for the analog drivers and the mode flag. A new reset strobe restarts the handshake from any state.

Top module: `hs_chirp_negotiator`

## Requirements
- R1: While `rstN` is low, and afterwards until the first reset strobe, all four outputs are low, whatever the line state.
- R2: A cycle with `busResetStrobe` high restarts the handshake from any state. From the next cycle `dpPullupEn` is high and the other three outputs are low. All timers, the filter and the pair count are cleared, so pairs counted before the strobe no longer count.
- R3: While waiting after a strobe, the first sample with line code 0 (SE0) raises `chirpKDrive` on the next cycle. The chirp then lasts exactly `CHIRP_TICKS` cycles unless R4 cuts it short.
- R4: The chirp always ends no later than `DEADLINE_TICKS` clock edges after the strobe edge, even when that leaves it shorter than `CHIRP_TICKS`.
- R5: If no SE0 is sampled within `DEADLINE_TICKS` edges after the strobe, no chirp is driven and the block settles at full-speed: `dpPullupEn` high and the other outputs low.
- R6: `lineState` is a 3-bit code: 0 is SE0, 1 is full-speed J, 2 is full-speed K, 3 is hub chirp J and 4 is hub chirp K. Only codes 3 and 4 can qualify during listening. Full-speed K/J activity never leads to high-speed.
- R7: A hub chirp level qualifies once it has been sampled on `FILT_TICKS` consecutive cycles, and it qualifies only once per run. Shorter runs are ignored, and any change of code restarts the filter.
- R8: A pair is a qualified chirp K followed by a qualified chirp J. A qualified J with no pending K is ignored.
- R9: On the edge where the `PAIRS`-th pair completes, the block enters high-speed: `hsTermEn` and `hsMode` high, `dpPullupEn` and `chirpKDrive` low. It stays there until the next strobe.
- R10: If `WTFS_TICKS` listening samples pass without the pair count being reached, the block enters full-speed (`dpPullupEn` high, others low) and stays there until the next strobe.
- R11: If the last pair completes on the same edge as the listening window closes, high-speed wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow handshake clock; one tick per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| busResetStrobe | input | 1 | One-cycle pulse: a bus reset has been detected |
| lineState | input | 3 | Decoded line level (0 SE0, 1 FS J, 2 FS K, 3 chirp J, 4 chirp K) |
| chirpKDrive | output | 1 | Enables the device chirp K driver |
| hsTermEn | output | 1 | Enables high-speed termination |
| dpPullupEn | output | 1 | Connects the full-speed pull-up on the positive data line |
| hsMode | output | 1 | High when high-speed operation was negotiated |

## Verification
The handshake is run with several line patterns:
- A silent hub separates the timeout path from the high-speed path.
- Clean K/J reply trains of full filter length confirm that high-speed is reached.
- Runs one tick shorter than the filter show that glitches are rejected.
- A train with only two pairs, and a train that opens with an orphan J, check the pairing rule.
- Full-speed K/J levels show that only chirp codes count.
- A late SE0 and an absent SE0 exercise the chirp deadline.
- A reply that completes on the very last listening tick settles the tie.
- A restart in the middle of a reply shows that earlier pairs are discarded.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

  typedef enum logic [2:0] {
    LN_SE0 = 3'd0,
    LN_FSJ = 3'd1,
    LN_FSK = 3'd2,
    LN_HSJ = 3'd3,
    LN_HSK = 3'd4
  } lineCode_t;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_SE0 = 3'd1,
    ST_CHIRP    = 3'd2,
    ST_LISTEN   = 3'd3,
    ST_FULL     = 3'd4,
    ST_HIGH     = 3'd5
  } negState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic clrChirp;
    logic clrListen;
    logic inChirp;
    logic inListen;
  } tmrCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic deadlineHit;
    logic chirpDone;
    logic waitExpired;
    logic pairDone;
  } tmrFlags_t;

endpackage

// File: rtl/chirp_timers.sv
module chirp_timers
  import chirp_pkg::*;
#(
  parameter int CHIRP_TICKS    = 20,
  parameter int DEADLINE_TICKS = 70,
  parameter int WTFS_TICKS     = 60,
  parameter int FILT_TICKS     = 3,
  parameter int PAIRS          = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  lineCode_t line,
  input  tmrCtl_t   ctl,
  output tmrFlags_t flags
);

  localparam int T0W = $clog2(DEADLINE_TICKS + 1);
  localparam int T2W = $clog2(CHIRP_TICKS + 1);
  localparam int T3W = $clog2(WTFS_TICKS + 1);
  localparam int RW  = $clog2(FILT_TICKS + 1);
  localparam int CW  = $clog2(PAIRS + 1);

  logic [T0W-1:0] sinceReset;
  logic [T2W-1:0] chirpAge;
  logic [T3W-1:0] listenAge;
  logic [RW-1:0]  runLen;
  logic [RW-1:0]  runNext;
  logic [CW-1:0]  pairCnt;
  lineCode_t      lastLvl;
  logic           kSeen;
  logic           newRun, isChirpLvl, qual, qualK, qualJ;

  // reset-duration timer, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceReset <= '0;
    else if (ctl.clrAll) sinceReset <= '0;
    else if (sinceReset != T0W'(DEADLINE_TICKS)) sinceReset <= sinceReset + 1'b1;
  end

  // device chirp length timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chirpAge <= '0;
    else if (ctl.clrAll || ctl.clrChirp) chirpAge <= '0;
    else if (ctl.inChirp && chirpAge != T2W'(CHIRP_TICKS)) chirpAge <= chirpAge + 1'b1;
  end

  // glitch filter and pair qualification
  always_comb begin
    newRun     = (line != lastLvl);
    isChirpLvl = (line == LN_HSJ) || (line == LN_HSK);
    if (newRun) runNext = RW'(1);
    else if (runLen == RW'(FILT_TICKS)) runNext = runLen;
    else runNext = runLen + 1'b1;
    qual  = isChirpLvl && (runNext == RW'(FILT_TICKS)) &&
            (newRun || runLen != RW'(FILT_TICKS));
    qualK = qual && (line == LN_HSK);
    qualJ = qual && (line == LN_HSJ) && kSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      listenAge <= '0;
      runLen    <= '0;
      lastLvl   <= LN_SE0;
      kSeen     <= 1'b0;
      pairCnt   <= '0;
    end else if (ctl.clrAll || ctl.clrListen) begin
      listenAge <= '0;
      runLen    <= '0;
      lastLvl   <= LN_SE0;
      kSeen     <= 1'b0;
      pairCnt   <= '0;
    end else if (ctl.inListen) begin
      if (listenAge != T3W'(WTFS_TICKS)) listenAge <= listenAge + 1'b1;
      runLen  <= runNext;
      lastLvl <= line;
      if (qualK) kSeen <= 1'b1;
      else if (qualJ) begin
        kSeen <= 1'b0;
        if (pairCnt != CW'(PAIRS)) pairCnt <= pairCnt + 1'b1;
      end
    end
  end

  always_comb begin
    flags.deadlineHit = (int'(sinceReset) + 1) >= DEADLINE_TICKS;
    flags.chirpDone   = (int'(chirpAge) + 1) >= CHIRP_TICKS;
    flags.waitExpired = (int'(listenAge) + 1) >= WTFS_TICKS;
    flags.pairDone    = qualJ && ((int'(pairCnt) + 1) >= PAIRS);
  end

  AST_PAIR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.inListen && !ctl.clrAll && !ctl.clrListen) |=>
      (pairCnt == $past(pairCnt) || pairCnt == $past(pairCnt) + 1'b1)); // R8

  AST_FILTER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(runLen) <= FILT_TICKS); // R7

  AST_LISTEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ctl.inListen |-> int'(listenAge) < WTFS_TICKS); // R10

  AST_CHIRP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ctl.inChirp |-> int'(chirpAge) < CHIRP_TICKS); // R3

endmodule

// File: rtl/chirp_ctrl.sv
module chirp_ctrl
  import chirp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busResetStrobe,
  input  lineCode_t line,
  input  tmrFlags_t flags,
  output tmrCtl_t   ctl,
  output logic      chirpKDrive,
  output logic      hsTermEn,
  output logic      dpPullupEn,
  output logic      hsMode
);

  negState_t state, nxt;

  always_comb begin
    nxt = state;
    ctl = '0;
    if (busResetStrobe) begin
      nxt        = ST_WAIT_SE0;
      ctl.clrAll = 1'b1;
    end else begin
      unique case (state)
        ST_WAIT_SE0: begin
          if (line == LN_SE0) begin
            nxt          = ST_CHIRP;
            ctl.clrChirp = 1'b1;
          end else if (flags.deadlineHit) begin
            nxt = ST_FULL;
          end
        end
        ST_CHIRP: begin
          ctl.inChirp = 1'b1;
          if (flags.chirpDone || flags.deadlineHit) begin
            nxt           = ST_LISTEN;
            ctl.clrListen = 1'b1;
          end
        end
        ST_LISTEN: begin
          ctl.inListen = 1'b1;
          if (flags.pairDone) nxt = ST_HIGH;
          else if (flags.waitExpired) nxt = ST_FULL;
        end
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nxt;
  end

  always_comb begin
    chirpKDrive = (state == ST_CHIRP);
    hsTermEn    = (state == ST_HIGH);
    hsMode      = (state == ST_HIGH);
    dpPullupEn  = (state == ST_WAIT_SE0) || (state == ST_CHIRP) ||
                  (state == ST_LISTEN) || (state == ST_FULL);
  end

  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    busResetStrobe |=> state == ST_WAIT_SE0); // R2

  AST_SE0_CHIRP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_SE0 && line == LN_SE0 && !busResetStrobe) |=> state == ST_CHIRP); // R3

  AST_DEADLINE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHIRP && flags.deadlineHit && !busResetStrobe) |=> state == ST_LISTEN); // R4

  AST_HS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HIGH && !busResetStrobe) |=> state == ST_HIGH); // R9

endmodule

// File: rtl/hs_chirp_negotiator.sv
module hs_chirp_negotiator
  import chirp_pkg::*;
#(
  parameter int CHIRP_TICKS    = 20,
  parameter int DEADLINE_TICKS = 70,
  parameter int WTFS_TICKS     = 60,
  parameter int FILT_TICKS     = 3,
  parameter int PAIRS          = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busResetStrobe,
  input  logic [2:0] lineState,
  output logic       chirpKDrive,
  output logic       hsTermEn,
  output logic       dpPullupEn,
  output logic       hsMode
);

  lineCode_t lineCode;
  tmrCtl_t   tmrCtl;
  tmrFlags_t tmrFlags;

  assign lineCode = lineCode_t'(lineState);

  chirp_ctrl i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .busResetStrobe(busResetStrobe),
    .line          (lineCode),
    .flags         (tmrFlags),
    .ctl           (tmrCtl),
    .chirpKDrive   (chirpKDrive),
    .hsTermEn      (hsTermEn),
    .dpPullupEn    (dpPullupEn),
    .hsMode        (hsMode)
  );

  chirp_timers #(
    .CHIRP_TICKS   (CHIRP_TICKS),
    .DEADLINE_TICKS(DEADLINE_TICKS),
    .WTFS_TICKS    (WTFS_TICKS),
    .FILT_TICKS    (FILT_TICKS),
    .PAIRS         (PAIRS)
  ) i_timers (
    .clk  (clk),
    .rstN (rstN),
    .line (lineCode),
    .ctl  (tmrCtl),
    .flags(tmrFlags)
  );

endmodule

// File: tb/test_hs_chirp_negotiator.sv
module test_hs_chirp_negotiator;

  localparam int CLK_PERIOD = 10;
  localparam int CHIRP  = 20;
  localparam int DEADL  = 70;
  localparam int WTFS   = 60;
  localparam int FILT   = 3;
  localparam int NPAIR  = 3;
  localparam int WATCHDOG = 100000;

  localparam int M_IDLE = 0, M_WAIT = 1, M_CHIRP = 2, M_LISTEN = 3, M_FULL = 4, M_HIGH = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busResetStrobe = 1'b0;
  logic [2:0] lineState = 3'd0;
  logic chirpKDrive, hsTermEn, dpPullupEn, hsMode;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  int chirpCnt = 0;
  bit doneFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_chirp_negotiator #(
    .CHIRP_TICKS(CHIRP), .DEADLINE_TICKS(DEADL), .WTFS_TICKS(WTFS),
    .FILT_TICKS(FILT), .PAIRS(NPAIR)
  ) i_hs_chirp_negotiator (
    .clk(clk), .rstN(rstN), .busResetStrobe(busResetStrobe), .lineState(lineState),
    .chirpKDrive(chirpKDrive), .hsTermEn(hsTermEn), .dpPullupEn(dpPullupEn), .hsMode(hsMode)
  );

  // behavioural reference model
  int mState = M_IDLE;
  int elapsed = 0, chirpLen = 0, waitLen = 0, pairs = 0;
  bit kPending = 0;
  int hist[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mState = M_IDLE;
    end else if (busResetStrobe) begin
      mState = M_WAIT; elapsed = 0; chirpLen = 0; waitLen = 0;
      pairs = 0; kPending = 0; hist.delete();
    end else begin
      elapsed++;
      case (mState)
        M_WAIT: begin
          if (lineState == 3'd0) begin mState = M_CHIRP; chirpLen = 0; end
          else if (elapsed >= DEADL) mState = M_FULL;
        end
        M_CHIRP: begin
          chirpLen++;
          if (chirpLen >= CHIRP || elapsed >= DEADL) begin
            mState = M_LISTEN; waitLen = 0; pairs = 0; kPending = 0; hist.delete();
          end
        end
        M_LISTEN: begin
          int lvl, run;
          bit completed;
          completed = 0;
          waitLen++;
          lvl = int'(lineState);
          hist.push_back(lvl);
          run = 0;
          for (int i = hist.size() - 1; i >= 0; i--) begin
            if (hist[i] != lvl) break;
            run++;
          end
          if (run == FILT && (lvl == 3 || lvl == 4)) begin
            if (lvl == 4) kPending = 1;
            else if (kPending) begin
              kPending = 0; pairs++;
              if (pairs >= NPAIR) completed = 1;
            end
          end
          if (completed) mState = M_HIGH;
          else if (waitLen >= WTFS) mState = M_FULL;
        end
        default: ;
      endcase
    end
  end

  function automatic string tagOf(int s);
    case (s)
      M_IDLE:   return "R1";
      M_WAIT:   return "R2";
      M_CHIRP:  return "R3";
      M_LISTEN: return "R7";
      M_FULL:   return "R10";
      default:  return "R9";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !doneFlag) begin
      logic [3:0] act, exp;
      act = {chirpKDrive, hsTermEn, dpPullupEn, hsMode};
      exp = {mState == M_CHIRP, mState == M_HIGH,
             mState == M_WAIT || mState == M_CHIRP || mState == M_LISTEN || mState == M_FULL,
             mState == M_HIGH};
      vectors++;
      if (act !== exp) begin
        miscompares++;
        $display("FAIL %s model compare at cycle %0d: actual=%b expected=%b",
                 tagOf(mState), cycles, act, exp);
      end
      if (chirpKDrive) chirpCnt++;
    end
  end

  task automatic checkOuts(string tag, logic [3:0] exp);
    logic [3:0] act;
    act = {chirpKDrive, hsTermEn, dpPullupEn, hsMode};
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s outputs {chirp,term,pullup,hs}: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic checkInt(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s chirp length: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hold(int code, int n);
    lineState = 3'(code);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int code);
    lineState = 3'(code);
    busResetStrobe = 1'b1;
    @(negedge clk);
    busResetStrobe = 1'b0;
  endtask

  task automatic hubPair(int kLen, int jLen);
    hold(4, kLen);
    hold(3, jLen);
  endtask

  localparam logic [3:0] O_IDLE = 4'b0000;
  localparam logic [3:0] O_WAIT = 4'b0010;
  localparam logic [3:0] O_FULL = 4'b0010;
  localparam logic [3:0] O_HIGH = 4'b0101;

  task automatic finishRun();
    doneFlag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !doneFlag) begin
      miscompares++;
      $display("FAIL watchdog (all requirements): actual=%0d cycles expected below %0d",
               cycles, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOuts("R1 in reset", O_IDLE);
    rstN = 1'b1;
    hold(0, 4);
    hold(4, 4);
    checkOuts("R1 idle ignores line", O_IDLE);

    // silent hub -> full-speed after the window
    pulse(0);
    checkOuts("R2 strobe from idle", O_WAIT);
    chirpCnt = 0;
    hold(0, 1 + CHIRP);
    checkInt("R3 normal chirp", chirpCnt, CHIRP);
    hold(0, WTFS + 5);
    checkOuts("R10 silent hub", O_FULL);

    // clean reply -> high-speed
    pulse(0);
    hold(0, 1 + CHIRP);
    repeat (3) hubPair(5, 5);
    hold(0, 3);
    checkOuts("R9 three pairs", O_HIGH);
    hold(0, 20);
    checkOuts("R9 stays high", O_HIGH);
    pulse(0);
    checkOuts("R2 strobe from high", O_WAIT);

    // glitches shorter than the filter
    hold(0, 1 + CHIRP);
    repeat (8) hubPair(FILT - 1, FILT - 1);
    hold(0, WTFS);
    checkOuts("R7 short runs ignored", O_FULL);

    // only two pairs
    pulse(0);
    hold(0, 1 + CHIRP);
    repeat (2) hubPair(5, 5);
    hold(0, WTFS);
    checkOuts("R8 two pairs only", O_FULL);

    // orphan J first, then three pairs
    pulse(0);
    hold(0, 1 + CHIRP);
    hold(3, 5);
    repeat (3) hubPair(5, 5);
    hold(0, 2);
    checkOuts("R8 orphan J ignored", O_HIGH);

    // full-speed K/J never count
    pulse(0);
    hold(0, 1 + CHIRP);
    repeat (4) begin hold(2, 5); hold(1, 5); end
    hold(0, WTFS);
    checkOuts("R6 FS levels ignored", O_FULL);

    // no SE0 before deadline
    pulse(1);
    chirpCnt = 0;
    hold(1, DEADL + 5);
    checkOuts("R5 no SE0", O_FULL);
    checkInt("R5 no chirp", chirpCnt, 0);

    // late SE0 -> truncated chirp
    pulse(1);
    chirpCnt = 0;
    hold(1, DEADL - 10);
    hold(0, CHIRP + 5);
    checkInt("R4 truncated chirp", chirpCnt, 9);

    // completion on the last listening sample
    pulse(0);
    hold(0, 1 + CHIRP);
    hold(0, WTFS - (25 + FILT));
    hubPair(5, 5);
    hubPair(5, 5);
    hold(4, 5);
    hold(3, FILT);
    hold(0, 2);
    checkOuts("R11 tie goes high", O_HIGH);

    // restart mid-reply discards earlier pairs
    pulse(0);
    hold(0, 1 + CHIRP);
    repeat (2) hubPair(5, 5);
    pulse(0);
    checkOuts("R2 restart mid-listen", O_WAIT);
    hold(0, 1 + CHIRP);
    hubPair(5, 5);
    hold(0, WTFS);
    checkOuts("R2 pair count cleared", O_FULL);

    finishRun();
  end

endmodule